// File: doc/BRIEF.md
# Open-Drain Line Direction Arbiter

This block joins open-drain data lines between a card and a host controller when neither side owns the direction. Each lane watches the sampled level of its card-side line and its host-side line. The first side that falls low becomes the talker. The bridge then pulls the other side low, which makes it the listener. It keeps pulling until the talker's line rises again. Then it lets go of both lines, and their pull-ups return them high.

Direction is never an input. It is latched from the first falling edge and dropped on the talker's rising edge. The fall that the bridge's own pull causes on the listener side therefore cannot turn the bridge around, so the lane cannot lock up.

Several lanes are built side by side, one for each data line, for example a main data line and two auxiliary lines. They share two control inputs:
- A session input that says the card interface is in reception mode. Outside a session, every card-side line is held low.
- An enable bit. When it is clear, the bridge leaves every line undriven.

Top module: `od_bridge_array`

## Requirements
- R1: While reset is high and on the first cycle after it, every card-side pull output is 1 (line held low) and every host-side pull output is 0.
- R2: When `rx_mode_i` is 0, one cycle later every card-side pull is 1 and every host-side pull is 0, even during a transfer. When `rx_mode_i` returns to 1, all card-side pulls drop one cycle later.
- R3: With `rx_mode_i` at 1 and `en_i` at 0, one cycle later no pull output of any lane is 1.
- R4: In an idle lane, a host-side fall alone sets that lane's card pull to 1. This happens exactly SYNC_STAGES+1 cycles after the line change, and not one cycle earlier.
- R5: In an idle lane, a card-side fall alone sets that lane's host pull to 1 after the same latency.
- R6: A rising edge on the talker's line clears the listener pull SYNC_STAGES+1 cycles after the line rises.
- R7: While a direction is latched, the listener pull stays set no matter what happens on the listener side, including the fall caused by the bridge's own pull. After release the lane does not latch the reverse direction.
- R8: If both lines of an idle lane fall in the same sample, the card side is taken as talker: the host pull is 1 and the card pull is 0.
- R9: After a release, a session start or a disable, a lane latches no direction until both of its synchronized lines have been seen high. A fall seen while the other line is still low drives nothing.
- R10: Lanes work independently. Bit i of every vector port belongs to lane i, and transfers on different lanes in opposite directions are served at the same time.
- R11: Clearing `en_i` in the middle of a transfer releases both lines of that lane on the next cycle. After `en_i` is set again, the lane returns to idle once both lines are high, and then it serves new transfers normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_mode_i | input | 1 | Card interface in reception mode; 0 forces every card line low |
| en_i | input | 1 | Bridge enable; 0 leaves all lines undriven |
| card_lvl_i | input | LINES | Sampled level of each card-side line |
| host_lvl_i | input | LINES | Sampled level of each host-side line |
| card_pull_o | output | LINES | 1 pulls the card-side line low |
| host_pull_o | output | LINES | 1 pulls the host-side line low |

## Verification
Assertions inside each lane check the following on every clock:
- the single-cycle response to the session input and the enable bit;
- which side each detected fall selects, including the tie rule;
- that the listener pull stays held while latched;
- that release follows the talker's rising edge;
- that nothing is driven while the lane is settling.

Only the bench scenarios can show the end-to-end behaviour with real lines. These cover the exact port latency through the synchronizers, the absence of lock-up once the echo of the bridge's own pull has travelled back, the per-lane independence, and the recovery after a disable or a session restart with lines still held low.

// File: rtl/od_bridge_pkg.sv
`timescale 1ns/1ps
package od_bridge_pkg;

  // Lane states of the direction arbiter
  typedef enum logic [2:0] {
    ST_FORCE   = 3'd0,  // outside a session: card line held low
    ST_SETTLE  = 3'd1,  // undriven, waiting for both lines high
    ST_IDLE    = 3'd2,  // undriven, watching for the first fall
    ST_CARD_IN = 3'd3,  // card talks, host side pulled low
    ST_HOST_IN = 3'd4   // host talks, card side pulled low
  } lane_state_e;

endpackage

// File: rtl/od_level_sync.sv
`timescale 1ns/1ps
module od_level_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RESET_LVL;
        else     chain_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_LVL}};
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/od_edge_tap.sv
`timescale 1ns/1ps
module od_edge_tap (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic fall_o,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
  assign rise_o = ~prev_q & lvl_i;

endmodule

// File: rtl/od_lane_arbiter.sv
`timescale 1ns/1ps
module od_lane_arbiter
  import od_bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_mode_i,
  input  logic en_i,
  input  logic card_lvl_i,
  input  logic host_lvl_i,
  output logic card_pull_o,
  output logic host_pull_o
);

  localparam int SIDES = 2;
  localparam int CARD  = 0;
  localparam int HOST  = 1;

  logic [SIDES-1:0] raw_lvl, lvl_s, fall_s, rise_s;
  lane_state_e state_q, state_d;
  logic card_pull_q, host_pull_q;

  assign raw_lvl = {host_lvl_i, card_lvl_i};

  // One synchronizer and edge detector per side
  generate
    for (genvar g = 0; g < SIDES; g++) begin : g_side
      od_level_sync #(.STAGES(SYNC_STAGES), .RESET_LVL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_lvl[g]),
        .q_o (lvl_s[g])
      );
      od_edge_tap u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (lvl_s[g]),
        .fall_o (fall_s[g]),
        .rise_o (rise_s[g])
      );
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    if (!rx_mode_i) begin
      state_d = ST_FORCE;
    end else if (!en_i) begin
      state_d = ST_SETTLE;
    end else begin
      case (state_q)
        ST_FORCE:   state_d = ST_SETTLE;
        ST_SETTLE:  if (&lvl_s) state_d = ST_IDLE;
        ST_IDLE: begin
          // card side wins a same-sample tie
          if (fall_s[CARD])      state_d = ST_CARD_IN;
          else if (fall_s[HOST]) state_d = ST_HOST_IN;
        end
        ST_CARD_IN: if (rise_s[CARD]) state_d = ST_SETTLE;
        ST_HOST_IN: if (rise_s[HOST]) state_d = ST_SETTLE;
        default:    state_d = ST_FORCE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_FORCE;
      card_pull_q <= 1'b1;
      host_pull_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      card_pull_q <= (state_d == ST_FORCE) || (state_d == ST_HOST_IN);
      host_pull_q <= (state_d == ST_CARD_IN);
    end
  end

  assign card_pull_o = card_pull_q;
  assign host_pull_o = host_pull_q;

  // Assertions
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> card_pull_o && !host_pull_o);

  assert_force_card_R2: assert property (@(posedge clk) disable iff (rst)
    !rx_mode_i |=> card_pull_o && !host_pull_o);

  assert_disable_release_R3: assert property (@(posedge clk) disable iff (rst)
    rx_mode_i && !en_i |=> !card_pull_o && !host_pull_o);

  assert_host_first_R4: assert property (@(posedge clk) disable iff (rst)
    rx_mode_i && en_i && state_q == ST_IDLE && fall_s[HOST] && !fall_s[CARD]
    |=> card_pull_o && !host_pull_o);

  assert_card_first_R5: assert property (@(posedge clk) disable iff (rst)
    rx_mode_i && en_i && state_q == ST_IDLE && fall_s[CARD] && !fall_s[HOST]
    |=> host_pull_o && !card_pull_o);

  assert_talker_release_R6: assert property (@(posedge clk) disable iff (rst)
    rx_mode_i && en_i &&
    ((state_q == ST_CARD_IN && rise_s[CARD]) || (state_q == ST_HOST_IN && rise_s[HOST]))
    |=> !card_pull_o && !host_pull_o);

  assert_echo_hold_R7: assert property (@(posedge clk) disable iff (rst)
    rx_mode_i && en_i && state_q == ST_CARD_IN && !rise_s[CARD] |=> host_pull_o);

  assert_tie_card_R8: assert property (@(posedge clk) disable iff (rst)
    rx_mode_i && en_i && state_q == ST_IDLE && fall_s[CARD] && fall_s[HOST]
    |=> host_pull_o && !card_pull_o);

  assert_settle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    rx_mode_i && en_i && state_q == ST_SETTLE && !(&lvl_s)
    |=> !card_pull_o && !host_pull_o);

endmodule

// File: rtl/od_bridge_array.sv
`timescale 1ns/1ps
module od_bridge_array #(
  parameter int LINES       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_mode_i,
  input  logic             en_i,
  input  logic [LINES-1:0] card_lvl_i,
  input  logic [LINES-1:0] host_lvl_i,
  output logic [LINES-1:0] card_pull_o,
  output logic [LINES-1:0] host_pull_o
);

  // One independent arbiter per line (R10)
  generate
    for (genvar i = 0; i < LINES; i++) begin : g_lane
      od_lane_arbiter #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
        .clk         (clk),
        .rst         (rst),
        .rx_mode_i   (rx_mode_i),
        .en_i        (en_i),
        .card_lvl_i  (card_lvl_i[i]),
        .host_lvl_i  (host_lvl_i[i]),
        .card_pull_o (card_pull_o[i]),
        .host_pull_o (host_pull_o[i])
      );
    end
  endgenerate

endmodule

// File: tb/od_bridge_array_test.sv
`timescale 1ns/1ps
module od_bridge_array_test;

  localparam int LINES = 3;
  localparam int SYNC  = 2;
  localparam int LAT   = SYNC + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_mode = 1'b0;
  logic en = 1'b0;
  logic [LINES-1:0] card_ext = '0;   // 1: outside party pulls card line low
  logic [LINES-1:0] host_ext = '0;   // 1: outside party pulls host line low
  logic [LINES-1:0] card_lvl, host_lvl, card_pull, host_pull;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Open-drain wires with pull-ups
  assign card_lvl = ~(card_pull | card_ext);
  assign host_lvl = ~(host_pull | host_ext);

  always #5 clk = ~clk;

  od_bridge_array #(.LINES(LINES), .SYNC_STAGES(SYNC)) uut (
    .clk         (clk),
    .rst         (rst),
    .rx_mode_i   (rx_mode),
    .en_i        (en),
    .card_lvl_i  (card_lvl),
    .host_lvl_i  (host_lvl),
    .card_pull_o (card_pull),
    .host_pull_o (host_pull)
  );

  function automatic logic [LINES-1:0] lane_bit(int lane);
    return LINES'(1) << lane;
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_pulls(string req, logic [LINES-1:0] exp_card, logic [LINES-1:0] exp_host);
    checks++;
    if (card_pull !== exp_card || host_pull !== exp_host) begin
      fails++;
      $display("FAIL %s: actual card=%b host=%b expected card=%b host=%b",
               req, card_pull, host_pull, exp_card, host_pull === exp_host ? host_pull : exp_host);
    end
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);
    @(negedge clk);
    step(2);
    expect_pulls("R1 during reset", '1, '0);
    rst = 1'b0;
    step(1);
    expect_pulls("R1 first cycle after reset", '1, '0);
    step(2);
    expect_pulls("R2 outside session", '1, '0);

    rx_mode = 1'b1; en = 1'b1;
    step(1);
    expect_pulls("R2 session start releases card", '0, '0);
    step(6);
    expect_pulls("R9 settled idle", '0, '0);

    // R4 host first, latency and R7 hold, R6 release
    host_ext[0] = 1'b1;
    step(LAT - 1);
    expect_pulls("R4 not one cycle early", '0, '0);
    step(1);
    expect_pulls("R4 host first drives card", 3'b001, '0);
    step(20);
    expect_pulls("R7 hold despite echo", 3'b001, '0);
    host_ext[0] = 1'b0;
    step(LAT);
    expect_pulls("R6 release on talker rise", '0, '0);
    step(8);
    expect_pulls("R7 no reverse latch after echo", '0, '0);

    // R5 card first
    card_ext[1] = 1'b1;
    step(LAT);
    expect_pulls("R5 card first drives host", '0, 3'b010);
    card_ext[1] = 1'b0;
    step(LAT);
    expect_pulls("R6 release card talker", '0, '0);
    step(8);

    // R8 tie, then R9 settle with listener still low externally
    card_ext[2] = 1'b1; host_ext[2] = 1'b1;
    step(LAT);
    expect_pulls("R8 tie picks card", '0, 3'b100);
    card_ext[2] = 1'b0;
    step(LAT);
    expect_pulls("R6 tie release", '0, '0);
    step(8);
    expect_pulls("R9 held-low line no latch", '0, '0);
    host_ext[2] = 1'b0;
    step(8);

    // R3 / R11 disable mid-transfer
    card_ext[0] = 1'b1;
    step(LAT);
    expect_pulls("R11 transfer before disable", '0, 3'b001);
    en = 1'b0;
    step(1);
    expect_pulls("R3 disable releases", '0, '0);
    en = 1'b1;
    step(1);
    host_ext[0] = 1'b1;
    step(LAT + 2);
    expect_pulls("R9 fall while other low ignored", '0, '0);
    card_ext[0] = 1'b0; host_ext[0] = 1'b0;
    step(8);
    card_ext[0] = 1'b1;
    step(LAT);
    expect_pulls("R11 serves again after reenable", '0, 3'b001);
    card_ext[0] = 1'b0;
    step(LAT + 8);

    // R2 session drop mid-transfer
    host_ext[1] = 1'b1;
    step(LAT);
    expect_pulls("R2 transfer before drop", 3'b010, '0);
    rx_mode = 1'b0;
    step(1);
    expect_pulls("R2 session drop forces card low", '1, '0);
    host_ext[1] = 1'b0; rx_mode = 1'b1;
    step(1);
    expect_pulls("R2 session restart", '0, '0);
    step(8);

    // R10 concurrent opposite directions
    card_ext[0] = 1'b1; host_ext[2] = 1'b1;
    step(LAT);
    expect_pulls("R10 independent lanes", 3'b100, 3'b001);
    card_ext[0] = 1'b0; host_ext[2] = 1'b0;
    step(LAT);
    expect_pulls("R10 independent release", '0, '0);
    step(8);

    // Random transfers
    for (int it = 0; it < 40; it++) begin
      int lane, mode, hold;
      bit other_low;
      lane = int'($urandom % LINES);
      mode = int'($urandom % 3);
      hold = 4 + int'($urandom % 30);
      other_low = 1'($urandom % 2);
      if (mode == 1) host_ext[lane] = 1'b1;
      else card_ext[lane] = 1'b1;
      if (mode == 2) host_ext[lane] = 1'b1;
      step(LAT);
      if (mode == 1) expect_pulls("R4 random host first", lane_bit(lane), '0);
      else if (mode == 0) expect_pulls("R5 random card first", '0, lane_bit(lane));
      else expect_pulls("R8 random tie", '0, lane_bit(lane));
      if (other_low && mode != 2) begin
        if (mode == 1) card_ext[lane] = 1'b1;
        else host_ext[lane] = 1'b1;
      end
      step(hold);
      if (mode == 1) expect_pulls("R7 random hold", lane_bit(lane), '0);
      else expect_pulls("R7 random hold", '0, lane_bit(lane));
      if (mode == 1) host_ext[lane] = 1'b0;
      else card_ext[lane] = 1'b0;
      step(LAT);
      expect_pulls("R6 random release", '0, '0);
      step(3);
      card_ext = '0; host_ext = '0;
      step(8);
      expect_pulls("R9 random settle", '0, '0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule